// File: doc/BRIEF.md
# DRAM Clock-Enable and Refresh Scheduler

This block owns the clock-enable pin of a four-bank DRAM and keeps the periodic refresh going. A free-running interval timer produces one refresh obligation per interval and holds it as a pending count. A refresh request is presented to the command arbiter while the count is non-zero and the clock is enabled. Each acknowledge retires one obligation. The interval is computed as a cycle count from a clock-frequency parameter: 7.8 µs in the normal temperature range. When the temperature input reports the hot range, the timer reloads with half that count.

When the host asks for idle, the block picks the low-power mode from the bank state. With every bank closed it enters precharge power-down. With any row open it enters active power-down. A separate self-refresh request is honoured only with every bank closed. Otherwise it is refused and a status flag is raised.

In power-down, refreshes are postponed. Once more than the allowed number are pending, the block wakes the device, drains the backlog through the arbiter, and returns to the mode it left. In self-refresh the device refreshes itself: the timer is frozen and no requests are issued.

Top module: `dram_pwr_refresh_ctl`

## Requirements
- R1: With `hot_range` low, `ref_req` rises once every `CLK_MHZ*7800/1000` cycles, and the first rise comes exactly that many cycles after reset is released.
- R2: With `hot_range` high, the interval is half the normal count (integer division). A change of `hot_range` takes effect at the next timer reload, so the gap already running keeps its old length.
- R3: With `pd_req` high, `rw_busy` low, no refresh pending and all `bank_open` bits zero, the next cycle shows `mode`=1 (precharge power-down) and `cke`=0.
- R4: Under the same conditions with any `bank_open` bit set, the next cycle shows `mode`=2 (active power-down) and `cke`=0.
- R5: While `rw_busy` is high, `cke` stays 1 and no power-down or self-refresh is entered, whatever the requests.
- R6: `sr_req` has priority over `pd_req`. With all banks closed, not busy and nothing pending, the next cycle shows `mode`=3 and `cke`=0. While in self-refresh, `ref_req` stays low and nothing accumulates. Dropping `sr_req` gives `mode`=0 and `cke`=1 on the next cycle. The first refresh follows one full interval after that exit edge.
- R7: `sr_req` with any bank open is refused. The block stays active (`mode`=0, `cke`=1, or `mode`=2 if `pd_req` is also high), and `sr_refused` is 1 on the next cycle.
- R8: In power-down, due refreshes are postponed with `ref_req` low. When the pending count exceeds `MAX_POSTPONE`, the next cycle shows `mode`=4 (refresh wake) and `cke`=1, exactly `(MAX_POSTPONE+1)` intervals after entry when the timer had just reloaded.
- R9: In refresh wake, `ref_req` stays high until every pending refresh is acknowledged, one per acknowledged cycle. The block then returns to the power-down mode it left if `pd_req` is still high, and to `mode`=0 otherwise.
- R10: Dropping `pd_req` in power-down gives `mode`=0 and `cke`=1 on the next cycle.
- R11: After reset, `cke`=1, `mode`=0, `ref_req`=0 and `sr_refused`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hot_range | input | 1 | 1 when case temperature is in the 85–95 °C range |
| bank_open | input | NUM_BANKS | One bit per bank, 1 when a row is open |
| rw_busy | input | 1 | A read or write access is in progress |
| pd_req | input | 1 | Host requests power-down while idle |
| sr_req | input | 1 | Host requests self-refresh |
| ref_ack | input | 1 | Arbiter accepted the refresh request this cycle |
| cke | output | 1 | DRAM clock enable |
| ref_req | output | 1 | Auto-refresh request to the arbiter |
| mode | output | 3 | 0 active, 1 precharge power-down, 2 active power-down, 3 self-refresh, 4 refresh wake |
| sr_refused | output | 1 | Self-refresh request refused because a bank is open |

## Verification
The bench builds the block with `CLK_MHZ`=5, which gives a 39-cycle normal interval and a 19-cycle hot interval, and with the default postponement limit of eight. At these values, whole refresh gaps can be measured and compared with the arithmetic count in both temperature ranges. The complete nine-interval postponement and its drain can be run for both power-down modes and both temperature ranges. All sixteen bank-open patterns can be swept for mode choice and self-refresh refusal.

// File: rtl/dram_pwr_refresh_ctl.sv
module dram_pwr_refresh_ctl #(
  parameter int CLK_MHZ      = 400,
  parameter int NUM_BANKS    = 4,
  parameter int MAX_POSTPONE = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hot_range,
  input  logic [NUM_BANKS-1:0] bank_open,
  input  logic                 rw_busy,
  input  logic                 pd_req,
  input  logic                 sr_req,
  input  logic                 ref_ack,
  output logic                 cke,
  output logic                 ref_req,
  output logic [2:0]           mode,
  output logic                 sr_refused
);
  localparam int REFI_FULL = CLK_MHZ * 7800 / 1000;
  localparam int REFI_HALF = REFI_FULL / 2;
  localparam int TW = $clog2(REFI_FULL);
  localparam int PW = $clog2(MAX_POSTPONE + 2);

  localparam logic [2:0] M_ACT  = 3'd0;
  localparam logic [2:0] M_PPD  = 3'd1;
  localparam logic [2:0] M_APD  = 3'd2;
  localparam logic [2:0] M_SR   = 3'd3;
  localparam logic [2:0] M_WAKE = 3'd4;

  logic [2:0]    mode_q, mode_d, saved_q;
  logic [TW-1:0] timer_q;
  logic [PW-1:0] pend_q;
  logic          refused_q;

  wire all_idle  = ~|bank_open;
  wire in_pd     = (mode_q == M_PPD) || (mode_q == M_APD);
  wire in_sr     = (mode_q == M_SR);
  wire tick      = !in_sr && (timer_q == '0);
  wire pend_full = &pend_q;
  wire over      = pend_q > PW'(MAX_POSTPONE);
  wire [TW-1:0] reload = hot_range ? TW'(REFI_HALF - 1) : TW'(REFI_FULL - 1);

  assign cke        = !(in_pd || in_sr);
  assign ref_req    = cke && (pend_q != '0);
  assign mode       = mode_q;
  assign sr_refused = refused_q;

  wire retire = ref_req && ref_ack;

  always_ff @(posedge clk) begin
    if (!rst_n)              timer_q <= TW'(REFI_FULL - 1);
    else if (in_sr || tick)  timer_q <= reload;
    else                     timer_q <= timer_q - TW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || in_sr) pend_q <= '0;
    else if (tick && !pend_full && !retire) pend_q <= pend_q + PW'(1);
    else if (!(tick && !pend_full) && retire) pend_q <= pend_q - PW'(1);
  end

  always_comb begin
    mode_d = mode_q;
    case (mode_q)
      M_ACT:
        if (!rw_busy && pend_q == '0) begin
          if (sr_req && all_idle) mode_d = M_SR;
          else if (pd_req)        mode_d = all_idle ? M_PPD : M_APD;
        end
      M_PPD, M_APD:
        if (!pd_req)   mode_d = M_ACT;
        else if (over) mode_d = M_WAKE;
      M_SR:
        if (!sr_req) mode_d = M_ACT;
      M_WAKE:
        if (pend_q == '0) mode_d = pd_req ? saved_q : M_ACT;
      default: mode_d = M_ACT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= M_ACT;
      saved_q   <= M_PPD;
      refused_q <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      if (mode_d == M_WAKE && mode_q != M_WAKE) saved_q <= mode_q;
      refused_q <= (mode_q == M_ACT) && sr_req && !all_idle;
    end
  end

  assert_busy_keeps_cke_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_ACT && rw_busy) |=> cke);

  assert_sr_entry_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SR && $past(mode_q) != M_SR) |-> ($past(bank_open) == '0));

  assert_sr_no_backlog_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_sr |-> !ref_req && pend_q == '0);

  assert_backlog_wakes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pd && pd_req && over) |=> (mode_q == M_WAKE && cke));

  assert_wake_retires_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_WAKE && ref_ack && pend_q != '0 && !tick) |=> pend_q == $past(pend_q) - PW'(1));

  assert_pd_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pd && !pd_req) |=> (mode_q == M_ACT && cke));
endmodule

// File: tb/dram_pwr_refresh_ctl_tb_top.sv
module dram_pwr_refresh_ctl_tb_top;
  localparam int CLK_MHZ = 5;
  localparam int NB = 4;
  localparam int MAXP = 8;
  localparam int FULL = CLK_MHZ * 7800 / 1000;
  localparam int HALF = FULL / 2;

  logic clk = 0, rst_n = 0, hot_range = 0, rw_busy = 0, pd_req = 0, sr_req = 0, ref_ack = 1;
  logic [NB-1:0] bank_open = '0;
  logic cke, ref_req, sr_refused;
  logic [2:0] mode;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dram_pwr_refresh_ctl #(.CLK_MHZ(CLK_MHZ), .NUM_BANKS(NB), .MAX_POSTPONE(MAXP)) dut_i (
    .clk(clk), .rst_n(rst_n), .hot_range(hot_range), .bank_open(bank_open), .rw_busy(rw_busy),
    .pd_req(pd_req), .sr_req(sr_req), .ref_ack(ref_ack), .cke(cke), .ref_req(ref_req),
    .mode(mode), .sr_refused(sr_refused));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wait_ref(output int n);
    n = 0;
    do begin step(); n++; end while (!ref_req && n < 5000);
  endtask

  task automatic settle();
    int n;
    wait_ref(n);
    step();
  endtask

  task automatic postpone_run(input bit hot, input logic [NB-1:0] banks, input bit drop_in_wake);
    int n, hits, per;
    hot_range = hot;
    settle(); settle();
    per = hot ? HALF : FULL;
    bank_open = banks;
    pd_req = 1;
    n = 0; hits = 0;
    do begin step(); n++; if (ref_req && !cke) hits++; end while (mode != 3'd4 && n < 5000);
    chk("R8 wake delay", n, (MAXP + 1) * per);
    chk("R8 no request in power-down", hits, 0);
    chk("R8 cke in wake", int'(cke), 1);
    if (drop_in_wake) pd_req = 0;
    hits = 0;
    while (mode == 3'd4) begin hits += int'(ref_req); step(); end
    chk("R9 drained count", hits, MAXP + 1);
    chk("R9 return mode", int'(mode), drop_in_wake ? 0 : (banks == '0 ? 1 : 2));
    pd_req = 0;
    step();
    chk("R10 exit mode", int'(mode), 0);
    chk("R10 exit cke", int'(cke), 1);
    bank_open = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R11 cke", int'(cke), 1);
    chk("R11 mode", int'(mode), 0);
    chk("R11 ref_req", int'(ref_req), 0);
    chk("R11 sr_refused", int'(sr_refused), 0);
    rst_n = 1;

    wait_ref(n); chk("R1 first interval", n, FULL);
    for (int i = 0; i < 3; i++) begin wait_ref(n); chk("R1 interval", n, FULL); end
    hot_range = 1;
    wait_ref(n); chk("R2 old reload kept", n, FULL);
    for (int i = 0; i < 2; i++) begin wait_ref(n); chk("R2 hot interval", n, HALF); end
    hot_range = 0;
    wait_ref(n); chk("R2 hot reload kept", n, HALF);
    wait_ref(n); chk("R1 back to normal", n, FULL);

    step();
    for (int b = 0; b < 16; b++) begin
      while (ref_req) step();
      bank_open = NB'(b); pd_req = 1;
      step();
      if (b == 0) begin chk("R3 mode", int'(mode), 1); chk("R3 cke", int'(cke), 0); end
      else begin chk("R4 mode", int'(mode), 2); chk("R4 cke", int'(cke), 0); end
      pd_req = 0;
      step();
      chk("R10 mode", int'(mode), 0);
      chk("R10 cke", int'(cke), 1);
    end

    bank_open = '0; rw_busy = 1; pd_req = 1; sr_req = 1;
    for (int i = 0; i < 6; i++) begin
      step(); chk("R5 cke held", int'(cke), 1); chk("R5 mode held", int'(mode), 0);
    end
    rw_busy = 0; pd_req = 0; sr_req = 0;

    settle();
    pd_req = 1; sr_req = 1;
    step();
    chk("R6 mode", int'(mode), 3);
    chk("R6 cke", int'(cke), 0);
    pd_req = 0;
    n = 0;
    for (int i = 0; i < 3 * FULL; i++) begin step(); n += int'(ref_req); n += int'(mode != 3'd3); end
    chk("R6 quiet in self-refresh", n, 0);
    sr_req = 0;
    wait_ref(n);
    chk("R6 first interval after exit", n, FULL + 1);
    step();
    for (int b = 1; b < 16; b++) begin
      while (ref_req) step();
      bank_open = NB'(b); sr_req = 1; pd_req = b[0];
      step();
      chk("R7 refused flag", int'(sr_refused), 1);
      chk("R7 mode", int'(mode), b[0] ? 2 : 0);
      sr_req = 0; pd_req = 0;
      step();
      chk("R7 flag clears", int'(sr_refused), 0);
    end
    bank_open = '0;

    postpone_run(0, '0, 0);
    postpone_run(0, 4'b0010, 0);
    postpone_run(1, '0, 0);
    postpone_run(1, 4'b1000, 0);
    postpone_run(0, 4'b0001, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule